// File: doc/BRIEF.md
# Dual-Mode Wake-Up Countdown Timer

This peripheral counts down a 64-bit value, one step per tick-enable pulse, and raises a level interrupt when the count runs out. Its purpose is to wake a sleeping processor. Software reaches it through a small register port with address, write data, write enable, read enable and read data.

The 64-bit reload value is written as two 32-bit halves. One control bit picks the mode:

- **Periodic mode:** the counter reloads on every expiry and keeps running.
- **Single-shot mode:** the counter stops at zero after one expiry.

The pending flag is cleared by writing 1 to it. It is kept apart from the enable and unmask bits.

The usual programming order is:

1. Stop the timer.
2. Choose the mode.
3. Write both halves of the reload value.
4. Start the timer by writing run, mode and unmask in one control write.

Top module: `wake_timer`

## Requirements
- R1: Registers sit at these byte offsets, and each reads back its stored value:
  - reload low half at 0x00;
  - reload high half at 0x04;
  - control at 0x10, with run in bit 0, single-shot in bit 1 and unmask in bit 2, and bits above 2 reading 0;
  - status at 0x18, with the pending flag in bit 0.
  Any other offset reads 0, and read data is 0 while read enable is low. Read data is combinational in the same cycle.
- R2: After reset every register reads 0 and the interrupt output is low.
- R3: A control write that sets run while run was 0 loads the counter from {high, low}. While run is 1 each tick pulse decrements the counter. While run is 0, tick pulses leave the count unchanged.
- R4: Expiry happens on the tick that finds the counter at zero. With reload value L, the flag is set one clock edge after the (L+1)-th tick that follows the start.
- R5: In periodic mode (bit 1 = 0), expiry reloads the counter from {high, low}, so the flag comes back every L+1 ticks.
- R6: In single-shot mode (bit 1 = 1), expiry holds the counter at zero with no further expiry. Clearing run and setting it again starts a new count.
- R7: The interrupt output is high exactly when the pending flag and the unmask bit are both 1. A masked flag still reads back as 1 in status bit 0.
- R8: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R9: When an expiry and a clear write fall in the same cycle, the flag ends up set.
- R10: A control write with run = 1 while already running does not reload the counter.
- R11: The high half takes part in the count: a nonzero high half delays expiry beyond the low half's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| tick_en | input | 1 | One-cycle count pulse |
| irq | output | 1 | Level interrupt: flag AND unmask |

## Verification
Every write takes effect on the clock edge that samples it. The flag and interrupt output rise on the same edge that samples the expiring tick, with no further pipeline stage. Read data is combinational and is valid in the cycle read enable is high.

The bench changes inputs on the falling edge and samples one falling edge after each rising edge. Expiry is therefore checked exactly after the L-th tick (still low) and after the (L+1)-th tick (high). This pins the period to the cycle rather than to a window.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int WT_OFS_LO   = 'h00;
    localparam int WT_OFS_HI   = 'h04;
    localparam int WT_OFS_CTRL = 'h10;
    localparam int WT_OFS_STAT = 'h18;

    // bit 0 run, bit 1 single-shot, bit 2 unmask
    typedef struct packed {
        logic unmask;
        logic one_shot;
        logic run;
    } wt_ctrl_t;

    localparam int WT_CTRL_W = $bits(wt_ctrl_t);
endpackage

// File: rtl/wt_regs.sv
module wt_regs
    import wt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  we,
    input  logic                  re,
    input  logic                  expire,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*DATA_W-1:0]   load_val,
    output wt_ctrl_t              ctrl,
    output logic                  start,
    output logic                  flag
);
    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        wt_ctrl_t          ctrl;
        logic              flag;
    } regs_t;

    regs_t st_d, st_q;

    logic sel_lo, sel_hi, sel_ctrl, sel_stat, clr_req;

    always_comb begin
        sel_lo   = (addr == ADDR_W'(WT_OFS_LO));
        sel_hi   = (addr == ADDR_W'(WT_OFS_HI));
        sel_ctrl = (addr == ADDR_W'(WT_OFS_CTRL));
        sel_stat = (addr == ADDR_W'(WT_OFS_STAT));
        clr_req  = we && sel_stat && wdata[0];

        st_d  = st_q;
        start = 1'b0;
        if (we && sel_lo)   st_d.lo = wdata;
        if (we && sel_hi)   st_d.hi = wdata;
        if (we && sel_ctrl) begin
            st_d.ctrl = wt_ctrl_t'(wdata[WT_CTRL_W-1:0]);
            start     = wdata[0] && !st_q.ctrl.run;
        end
        if (clr_req) st_d.flag = 1'b0;
        if (expire)  st_d.flag = 1'b1;   // new expiry beats a clear

        rdata = '0;
        if (re) begin
            if (sel_lo)        rdata = st_q.lo;
            else if (sel_hi)   rdata = st_q.hi;
            else if (sel_ctrl) rdata = {{(DATA_W-WT_CTRL_W){1'b0}}, st_q.ctrl};
            else if (sel_stat) rdata = {{(DATA_W-1){1'b0}}, st_q.flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_val = {st_q.hi, st_q.lo};
    assign ctrl     = st_q.ctrl;
    assign flag     = st_q.flag;

    p_expire_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !expire && !(we && sel_stat && wdata[0])) |=> flag);
endmodule

// File: rtl/wt_count.sv
module wt_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             one_shot,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        if (start) begin
            c_d.cnt  = load_val;
            c_d.done = 1'b0;
        end else if (run && tick && !c_q.done) begin
            if (c_q.cnt == '0) begin
                expire = 1'b1;
                if (one_shot) c_d.done = 1'b1;
                else          c_d.cnt  = load_val;
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_q.cnt == $past(load_val)) && !c_q.done);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(c_q.cnt));

    p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !one_shot) |=> c_q.cnt == $past(load_val));

    p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && one_shot) |=> (c_q.done && c_q.cnt == '0));
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    wt_ctrl_t         ctrl;
    logic [CNT_W-1:0] load_val;
    logic             start, expire, flag;

    wt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .re(bus_re), .expire(expire), .rdata(bus_rdata),
        .load_val(load_val), .ctrl(ctrl), .start(start), .flag(flag)
    );

    wt_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .one_shot(ctrl.one_shot),
        .tick(tick_en), .start(start), .load_val(load_val), .expire(expire)
    );

    assign irq = flag && ctrl.unmask;
endmodule

// File: tb/wake_timer_tb_top.sv
module wake_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_CTRL = 5'h10, A_STAT = 5'h18;

    // {single_shot, reload_low}
    localparam int NVEC = 6;
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b0, 32'd0}, {1'b1, 32'd0}, {1'b0, 32'd3},
        {1'b1, 32'd5}, {1'b0, 32'd9}, {1'b1, 32'd1}
    };

    always #4 clk = ~clk;

    wake_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic arm(input logic [31:0] lo, input logic [31:0] hi, input logic ss);
        wr(A_CTRL, 32'd0);
        wr(A_CTRL, {29'd0, 1'b1, ss, 1'b0});
        wr(A_LO, lo);
        wr(A_HI, hi);
        wr(A_STAT, 32'd1);
        wr(A_CTRL, {29'd0, 1'b1, ss, 1'b1});
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(A_LO, v);   chk("R2 lo", v, 0);
        rd(A_HI, v);   chk("R2 hi", v, 0);
        rd(A_CTRL, v); chk("R2 ctrl", v, 0);
        rd(A_STAT, v); chk("R2 stat", v, 0);
        chk("R2 irq", irq, 0);

        // R1 read back and decode
        wr(A_LO, 32'hA5A5_1234); rd(A_LO, v); chk("R1 lo", v, 32'hA5A5_1234);
        wr(A_HI, 32'h0000_00FF); rd(A_HI, v); chk("R1 hi", v, 32'h0000_00FF);
        wr(A_CTRL, 32'hFFFF_FFF6); rd(A_CTRL, v); chk("R1 ctrl bits", v, 32'h6);
        rd(5'h08, v); chk("R1 unmapped", v, 0);
        bus_addr = A_LO; #1 chk("R1 re low", bus_rdata, 0);
        wr(A_CTRL, 0); wr(A_HI, 0);

        // R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic ss;
            int   n;
            ss = VECS[i][32];
            n  = int'(VECS[i][31:0]);
            arm(VECS[i][31:0], 32'd0, ss);
            ticks(n);
            chk("R4 before expiry", irq, 0);
            ticks(1);
            chk("R4 at expiry", irq, 1);
            rd(A_STAT, v); chk("R4 status", v, 1);
            wr(A_STAT, 32'd1);
            ticks(n + 1);
            if (ss) chk("R6 no second expiry", irq, 0);
            else    chk("R5 periodic expiry", irq, 1);
            wr(A_STAT, 32'd1);
        end

        // R6 restart after single-shot
        arm(32'd2, 32'd0, 1'b1);
        ticks(3); wr(A_STAT, 1); ticks(6);
        chk("R6 held", irq, 0);
        wr(A_CTRL, 32'h6); wr(A_CTRL, 32'h7);
        ticks(2); chk("R6 restart early", irq, 0);
        ticks(1); chk("R6 restart expiry", irq, 1);

        // R3 ticks ignored while stopped; stop and restart reloads
        wr(A_CTRL, 0); wr(A_LO, 32'd2); wr(A_STAT, 1); wr(A_CTRL, 32'h4);
        ticks(5); rd(A_STAT, v); chk("R3 stopped no count", v, 0);
        wr(A_CTRL, 32'h5);
        ticks(2); chk("R3 count early", irq, 0);
        ticks(1); chk("R3 count expiry", irq, 1);
        arm(32'd3, 32'd0, 1'b0);
        ticks(2); wr(A_CTRL, 32'h4); ticks(5);
        chk("R3 paused", irq, 0);
        wr(A_CTRL, 32'h5);
        ticks(3); chk("R3 reload early", irq, 0);
        ticks(1); chk("R3 reload expiry", irq, 1);

        // R10 rewrite of run while running
        arm(32'd4, 32'd0, 1'b0);
        ticks(2); wr(A_CTRL, 32'h5);
        ticks(2); chk("R10 no reload early", irq, 0);
        ticks(1); chk("R10 no reload expiry", irq, 1);

        // R7 masking
        arm(32'd1, 32'd0, 1'b0);
        wr(A_CTRL, 32'h1);
        ticks(2); chk("R7 masked irq", irq, 0);
        rd(A_STAT, v); chk("R7 masked flag", v, 1);
        wr(A_CTRL, 32'h5); chk("R7 unmasked irq", irq, 1);

        // R8 write-one-to-clear
        wr(A_STAT, 32'h0); chk("R8 zero write", irq, 1);
        wr(A_STAT, 32'h1); chk("R8 clear", irq, 0);
        rd(A_STAT, v); chk("R8 status", v, 0);

        // R9 expiry and clear in the same cycle
        arm(32'd1, 32'd0, 1'b0);
        ticks(1);
        bus_addr = A_STAT; bus_wdata = 1; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        chk("R9 expiry wins", irq, 1);
        wr(A_STAT, 1); chk("R9 later clear", irq, 0);

        // R11 high half counts
        arm(32'd0, 32'd1, 1'b0);
        ticks(10); chk("R11 high half delays", irq, 0);
        wr(A_CTRL, 0); wr(A_HI, 0); wr(A_CTRL, 32'h5);
        ticks(1); chk("R11 high cleared", irq, 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule